// File: doc/BRIEF.md
# Write-Protect Register Unlock Sequencer

This block controls the write-protect register of a serial memory. The register sits at the highest address of the map. It holds two volatile latches: a write-enable latch and a register-unlock latch. It also holds three nonvolatile bits: a protect-enable bit and a two-bit block-lock field. The bus front end decodes each write into one transaction: an address, a data byte, and a flag that says whether the write ended with a stop or with a repeated start. The block then decides how that write moves the unlock sequence forward.

The nonvolatile bits change only through an ordered sequence. First the write-enable latch is set. Then the register-unlock latch is set. Finally a data byte carrying the new bit values is written and closed by a stop. That last write starts a timed nonvolatile cycle. While the cycle runs, the block refuses every new transaction, which lets the host poll until the cycle ends. An external write-protect pin, together with the protect-enable bit, can freeze the register. The block also checks array write requests against the write-enable latch and the block-lock range.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After reset, both latches are 0, busy is 0, and {protect-enable, lock1, lock0} equal the INIT_NV parameter.
- R2: An accepted write of 0x02 to the register address (all address bits 1) sets the write-enable latch. A write of 0x00 clears it, but only while the unlock latch is 0. Writes to any other address leave both latches unchanged.
- R3: An accepted write of 0x06 to the register address sets the unlock latch only when the write-enable latch is already 1. Otherwise the write is ignored. The unlock latch is never 1 while the write-enable latch is 0.
- R4: While the unlock latch is 1, a register write whose bits 6:5 are 00 and bits 2:0 are 010, ended by a stop, starts a nonvolatile cycle. Busy goes high the cycle after acceptance and stays high for exactly TWC cycles. When busy falls, protect-enable takes bit 7, lock1 takes bit 4 and lock0 takes bit 3. At the same time the unlock latch clears and the write-enable latch stays 1.
- R5: While the unlock latch is 1, a register byte of that form but with bit 2 set changes nothing and starts no cycle. The unlock latch stays 1.
- R6: A step-three byte ended by a repeated start (stop flag 0) starts no cycle. It changes no bit, and the unlock latch stays 1.
- R7: When the pin and protect-enable are both 1, a step-three write is aborted: no cycle starts and no bit changes. When the pin is 1 but protect-enable is 0, the write proceeds.
- R8: A transaction is accepted only while busy is 0. The acknowledge output pulses for one cycle, one cycle after an accepted transaction. A transaction presented while busy is not acknowledged and has no effect.
- R9: The protected flag, registered one cycle after the request, uses the array address top bits (12-bit default). Lock field 00 protects nothing. 01 protects addresses whose top two bits are 11. 10 protects addresses whose top bit is 1. 11 protects everything. The pin has no effect on this flag.
- R10: A grant appears one cycle after an array write request only if the write-enable latch is 1, busy is 0 and the address is not protected, all judged in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Decoded write transaction present |
| txn_addr | input | ADDR_W | Transaction address |
| txn_data | input | 8 | Transaction data byte |
| txn_stop | input | 1 | 1: ended with stop, 0: ended with repeated start |
| wp_pin | input | 1 | External write-protect pin |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | ARRAY_W | Array write address |
| txn_ack | output | 1 | Transaction accepted (registered) |
| busy | output | 1 | Nonvolatile cycle running |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-unlock latch |
| wpen | output | 1 | Stored protect-enable bit |
| bl | output | 2 | Stored block-lock field {lock1, lock0} |
| arr_wr_grant | output | 1 | Array write granted (registered) |
| arr_protected | output | 1 | Requested array address is protected (registered) |

## Verification
Two functions can land in the same cycle: an array write request, and the last busy cycle of a nonvolatile commit. The bench waits for the final busy cycle and presents an array request for an address that the new lock field will cover. The grant must be refused because busy is still high. The protected flag for that request must still follow the old lock field. The next request to the same address must then report the new protection. The bench also presents a register write during busy and judges it by a missing acknowledge and an unchanged unlock latch once busy ends.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bl;
  } nv_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WE,
    OP_CLR_WE,
    OP_SET_UNLK,
    OP_NV_START
  } wr_op_e;

  localparam logic [7:0] BYTE_SET_WE   = 8'h02;
  localparam logic [7:0] BYTE_SET_UNLK = 8'h06;
  localparam logic [7:0] BYTE_CLR_WE   = 8'h00;

endpackage

// File: rtl/wp_latch_fsm.sv
module wp_latch_fsm
  import wp_pkg::*;
#(
  parameter logic [2:0] INIT_NV = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic [7:0] data,
  input  logic       stop,
  input  logic       wp_pin,
  input  logic       commit,
  output logic       wel,
  output logic       rwel,
  output nv_t        nv,
  output logic       start_nv
);

  nv_t    pend_q;
  wr_op_e op;
  logic   step3_form;
  logic   locked;

  assign step3_form = (data[6:5] == 2'b00) && (data[1:0] == 2'b10);
  assign locked     = wp_pin & nv.wpen;

  always_comb begin
    op = OP_NONE;
    if (acc) begin
      if (rwel) begin
        if (step3_form && !data[2] && stop && !locked)
          op = OP_NV_START;
      end else begin
        if (data == BYTE_SET_WE)
          op = OP_SET_WE;
        else if (data == BYTE_CLR_WE)
          op = OP_CLR_WE;
        else if (data == BYTE_SET_UNLK && wel)
          op = OP_SET_UNLK;
      end
    end
  end

  assign start_nv = (op == OP_NV_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel    <= 1'b0;
      rwel   <= 1'b0;
      nv     <= nv_t'(INIT_NV);
      pend_q <= nv_t'(INIT_NV);
    end else begin
      unique case (op)
        OP_SET_WE:   wel  <= 1'b1;
        OP_CLR_WE:   wel  <= 1'b0;
        OP_SET_UNLK: rwel <= 1'b1;
        OP_NV_START: pend_q <= '{wpen: data[7], bl: data[4:3]};
        default: ;
      endcase
      if (commit) begin
        nv   <= pend_q;
        rwel <= 1'b0;
      end
    end
  end

  // R3
  rwel_implies_wel_chk: assert property (@(posedge clk) disable iff (rst)
    rwel |-> wel);

  // R4
  nv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(nv));

  // R7
  lock_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_nv |-> !(wp_pin && nv.wpen));

endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
  parameter int TWC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (TWC < 2) ? 1 : $clog2(TWC + 1);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(TWC - 1);
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R4
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: rtl/wp_block_guard.sv
module wp_block_guard #(
  parameter int ARRAY_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         bl,
  input  logic               wel,
  input  logic               busy,
  input  logic               req,
  input  logic [ARRAY_W-1:0] addr,
  output logic               grant,
  output logic               prot
);

  localparam int TOP = ARRAY_W - 1;

  logic hit;

  always_comb begin
    unique case (bl)
      2'b00:   hit = 1'b0;
      2'b01:   hit = addr[TOP] & addr[TOP-1];
      2'b10:   hit = addr[TOP];
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      prot  <= 1'b0;
    end else begin
      prot  <= req & hit;
      grant <= req & wel & ~busy & ~hit;
    end
  end

  // R9
  full_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (req && bl == 2'b11) |=> (prot && !grant));

  // R10
  no_grant_wo_wel_chk: assert property (@(posedge clk) disable iff (rst)
    !wel |=> !grant);

endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl
  import wp_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         ARRAY_W = 12,
  parameter int         TWC     = 20,
  parameter logic [2:0] INIT_NV = 3'b000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               txn_valid,
  input  logic [ADDR_W-1:0]  txn_addr,
  input  logic [7:0]         txn_data,
  input  logic               txn_stop,
  input  logic               wp_pin,
  input  logic               arr_wr_req,
  input  logic [ARRAY_W-1:0] arr_addr,
  output logic               txn_ack,
  output logic               busy,
  output logic               wel,
  output logic               rwel,
  output logic               wpen,
  output logic [1:0]         bl,
  output logic               arr_wr_grant,
  output logic               arr_protected
);

  localparam logic [ADDR_W-1:0] REG_ADDR = '1;

  logic accept;
  logic reg_acc;
  logic start_nv;
  logic commit;
  nv_t  nv;

  assign accept  = txn_valid & ~busy;
  assign reg_acc = accept & (txn_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) txn_ack <= 1'b0;
    else     txn_ack <= accept;
  end

  wp_latch_fsm #(.INIT_NV(INIT_NV)) i_fsm (
    .clk     (clk),
    .rst     (rst),
    .acc     (reg_acc),
    .data    (txn_data),
    .stop    (txn_stop),
    .wp_pin  (wp_pin),
    .commit  (commit),
    .wel     (wel),
    .rwel    (rwel),
    .nv      (nv),
    .start_nv(start_nv)
  );

  wp_cycle_timer #(.TWC(TWC)) i_timer (
    .clk  (clk),
    .rst  (rst),
    .start(start_nv),
    .busy (busy),
    .done (commit)
  );

  wp_block_guard #(.ARRAY_W(ARRAY_W)) i_guard (
    .clk  (clk),
    .rst  (rst),
    .bl   (nv.bl),
    .wel  (wel),
    .busy (busy),
    .req  (arr_wr_req),
    .addr (arr_addr),
    .grant(arr_wr_grant),
    .prot (arr_protected)
  );

  assign wpen = nv.wpen;
  assign bl   = nv.bl;

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && busy) |=> !txn_ack);

endmodule

// File: tb/test_wp_unlock_ctrl.sv
module test_wp_unlock_ctrl;

  localparam int TWC = 8;
  localparam logic [15:0] REG = 16'hFFFF;

  localparam logic [8:0] M_ACK  = 9'h100;
  localparam logic [8:0] M_BUSY = 9'h080;
  localparam logic [8:0] M_WEL  = 9'h040;
  localparam logic [8:0] M_RWEL = 9'h020;
  localparam logic [8:0] M_NV   = 9'h01C;
  localparam logic [8:0] M_GNT  = 9'h002;
  localparam logic [8:0] M_PRT  = 9'h001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_valid = 1'b0;
  logic [15:0] txn_addr = '0;
  logic [7:0]  txn_data = '0;
  logic        txn_stop = 1'b0;
  logic        wp_pin = 1'b0;
  logic        arr_wr_req = 1'b0;
  logic [11:0] arr_addr = '0;
  logic        txn_ack, busy, wel, rwel, wpen, arr_wr_grant, arr_protected;
  logic [1:0]  bl;

  wp_unlock_ctrl #(.ADDR_W(16), .ARRAY_W(12), .TWC(TWC), .INIT_NV(3'b000)) i_wp_unlock_ctrl (
    .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_addr(txn_addr),
    .txn_data(txn_data), .txn_stop(txn_stop), .wp_pin(wp_pin),
    .arr_wr_req(arr_wr_req), .arr_addr(arr_addr), .txn_ack(txn_ack),
    .busy(busy), .wel(wel), .rwel(rwel), .wpen(wpen), .bl(bl),
    .arr_wr_grant(arr_wr_grant), .arr_protected(arr_protected)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    logic [8:0] mask;
    logic [8:0] val;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] V(logic a, logic b, logic w, logic r,
                                   logic [2:0] n, logic g, logic p);
    return {a, b, w, r, n, g, p};
  endfunction

  task automatic push(input int due, input logic [8:0] m, input logic [8:0] v, input string r);
    item_t it;
    it.due = due; it.mask = m; it.val = v; it.req = r;
    q.push_back(it);
  endtask

  // monitor: pops and compares due items away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          logic [8:0] o;
          o = {txn_ack, busy, wel, rwel, wpen, bl, arr_wr_grant, arr_protected};
          checks++;
          if ((o & q[i].mask) !== (q[i].val & q[i].mask)) begin
            errors++;
            $display("FAIL %s cycle %0d actual %b expected %b mask %b",
                     q[i].req, cyc, o & q[i].mask, q[i].val & q[i].mask, q[i].mask);
          end
          q.delete(i);
        end
      end
    end
  end

  // driver tasks: called at a negedge, drive at once, return one negedge later
  task automatic send(input logic [15:0] a, input logic [7:0] d, input logic st,
                      input logic [8:0] m, input logic [8:0] v, input string r,
                      output int c);
    c = cyc;
    txn_valid = 1'b1; txn_addr = a; txn_data = d; txn_stop = st;
    push(c + 1, m, v, r);
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  task automatic areq(input logic [11:0] a, input logic [8:0] m, input logic [8:0] v,
                      input string r);
    arr_wr_req = 1'b1; arr_addr = a;
    push(cyc + 1, m, v, r);
    @(negedge clk);
    arr_wr_req = 1'b0;
  endtask

  task automatic wait_to(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c;
    int d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    push(cyc + 1, M_ACK | M_BUSY | M_WEL | M_RWEL | M_NV | M_GNT | M_PRT,
         V(0, 0, 0, 0, 3'b000, 0, 0), "R1");
    @(negedge clk);

    send(REG, 8'h06, 1, M_ACK | M_WEL | M_RWEL, V(1, 0, 0, 0, 0, 0, 0), "R3", d);
    send(16'h0123, 8'h02, 1, M_ACK | M_WEL, V(1, 0, 0, 0, 0, 0, 0), "R2", d);
    send(REG, 8'h02, 1, M_ACK | M_WEL | M_RWEL, V(1, 0, 1, 0, 0, 0, 0), "R2", d);
    areq(12'hFFF, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 1, 0), "R10");
    send(REG, 8'h06, 1, M_WEL | M_RWEL, V(0, 0, 1, 1, 0, 0, 0), "R3", d);
    send(REG, 8'h00, 1, M_WEL | M_RWEL | M_NV, V(0, 0, 1, 1, 3'b000, 0, 0), "R2", d);
    send(REG, 8'h8E, 1, M_BUSY | M_RWEL | M_NV, V(0, 0, 0, 1, 3'b000, 0, 0), "R5", d);
    send(REG, 8'h0A, 0, M_BUSY | M_RWEL | M_NV, V(0, 0, 0, 1, 3'b000, 0, 0), "R6", d);

    // R4 first commit: lock field becomes 01
    send(REG, 8'h0A, 1, M_ACK | M_BUSY, V(1, 1, 0, 0, 0, 0, 0), "R4", c);
    push(c + TWC, M_BUSY | M_NV | M_RWEL, V(0, 1, 0, 1, 3'b000, 0, 0), "R4");
    push(c + TWC + 1, M_BUSY | M_NV | M_RWEL | M_WEL, V(0, 0, 1, 0, 3'b001, 0, 0), "R4");
    // R8 write during busy: no ack, rwel then cleared by the commit only
    send(REG, 8'h06, 1, M_ACK | M_RWEL, V(0, 0, 0, 1, 0, 0, 0), "R8", d);
    // same-cycle case: request in the last busy cycle, judged on old lock field
    wait_to(c + TWC);
    areq(12'hC00, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 0, 0), "R10");
    areq(12'hC00, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 0, 1), "R9");
    areq(12'hBFF, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 1, 0), "R9");

    // R4 second commit: protect-enable 1, lock field 10
    send(REG, 8'h06, 1, M_RWEL, V(0, 0, 0, 1, 0, 0, 0), "R3", d);
    send(REG, 8'h92, 1, M_BUSY, V(0, 1, 0, 0, 0, 0, 0), "R4", c);
    push(c + TWC + 1, M_BUSY | M_NV | M_RWEL, V(0, 0, 0, 0, 3'b110, 0, 0), "R4");
    wait_to(c + TWC + 1);
    areq(12'h7FF, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 1, 0), "R9");
    areq(12'h800, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 0, 1), "R9");

    // R7 locked: pin 1 and protect-enable 1
    wp_pin = 1'b1;
    send(REG, 8'h06, 1, M_RWEL, V(0, 0, 0, 1, 0, 0, 0), "R3", d);
    send(REG, 8'h1A, 1, M_ACK | M_BUSY | M_NV | M_RWEL, V(1, 0, 0, 1, 3'b110, 0, 0), "R7", d);
    push(cyc + 1, M_BUSY | M_NV, V(0, 0, 0, 0, 3'b110, 0, 0), "R7");
    areq(12'h800, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 0, 1), "R9");

    // pin low: same byte proceeds, lock field 11
    wp_pin = 1'b0;
    send(REG, 8'h1A, 1, M_BUSY, V(0, 1, 0, 0, 0, 0, 0), "R4", c);
    push(c + TWC + 1, M_NV | M_RWEL, V(0, 0, 0, 0, 3'b011, 0, 0), "R4");
    wait_to(c + TWC + 1);
    areq(12'h000, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 0, 1), "R9");

    // R7 pin high but protect-enable 0: write proceeds
    wp_pin = 1'b1;
    send(REG, 8'h06, 1, M_RWEL, V(0, 0, 0, 1, 0, 0, 0), "R3", d);
    send(REG, 8'h02, 1, M_BUSY, V(0, 1, 0, 0, 0, 0, 0), "R7", c);
    push(c + TWC + 1, M_NV | M_RWEL | M_WEL, V(0, 0, 1, 0, 3'b000, 0, 0), "R7");
    wait_to(c + TWC + 1);
    areq(12'h000, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 1, 0), "R9");

    // R2 clear write-enable, then R10 refusal
    send(REG, 8'h00, 1, M_WEL | M_RWEL, V(0, 0, 0, 0, 0, 0, 0), "R2", d);
    areq(12'h100, M_GNT | M_PRT, V(0, 0, 0, 0, 0, 0, 0), "R10");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors += q.size();
      $display("FAIL pending checks actual %0d expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule